// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block is a synthesizable stand-in for a small serial EEPROM. It sits behind four pins: select, shift clock, serial data in and serial data out. The out pin has an enable, so it can share a board line. A strap input sets the width. When the strap is high, the array is 64 words of 16 bits. When it is low, the same storage is addressed as 128 bytes. The pins are sampled in the system clock domain. The shift clock must therefore run several times slower than the system clock.

A host opens a command by raising select. It then clocks in a start bit of 1, a two-bit opcode and an address. Any zeros before the start bit are skipped. For a write or a write-all, the data follows the address. A read answers with one zero bit, then the word, most significant bit first. Writes, erases and the bulk fills are refused until programming has been unlocked. Once started, each of these runs a timed programming cycle. The host polls that cycle by dropping select and raising it again. While select stays high, the out pin shows busy as 0 and ready as 1.

Top module: `tw_eeprom_target`

## Requirements
- R1: A command begins when select rises. Zeros clocked in before the first 1 are skipped. That 1 is the start bit, followed by a two-bit opcode and then the address. If select falls before the command is complete, the command is discarded: no storage changes and no programming cycle starts.
- R2: With `org16_i`=1 the address is 6 bits and data is 16 bits. With `org16_i`=0 the address is 7 bits and data is 8 bits. Byte address b selects word b>>1: bits 15:8 when b[0]=1, bits 7:0 when b[0]=0.
- R3: Opcode 10 is a read. From the rising shift-clock edge of the last address bit, the out pin is driven 0 (the dummy bit). Each later rising edge then presents the next data bit, most significant bit first. A read works whether programming is locked or not.
- R4: After reset, programming is locked. Opcode 00 with the top two address bits equal to 11 unlocks it, and 00 relocks it. While locked, write, erase, erase-all and write-all change nothing and start no programming cycle.
- R5: Opcode 01 stores the data word that follows the address into the addressed location.
- R6: Opcode 11 sets every bit of the addressed location to 1. In byte mode, the other byte of the same word keeps its value.
- R7: Opcode 00 with top address bits 10 sets the whole array to ones. Opcode 00 with top bits 01 writes the data that follows into every location; in byte mode the same byte goes into both halves of every word.
- R8: A programming cycle lasts `PROG_CYCLES` system clocks, or 2^`WADDR_W` clocks if that is longer. It starts on the last data bit, or on the last address bit for the erase commands. If select is dropped and raised again during the cycle, the out pin is driven 0 while busy and 1 once the cycle is done, for as long as select stays high.
- R9: If select is first raised again only after the cycle has ended, the out pin is not driven.
- R10: Once select has been raised during a programming cycle, all input until select falls is ignored. A command sent in that window neither reads nor changes storage.
- R11: The out pin enable is low whenever select is low. It is also low whenever neither read data nor status is being shown. One more rising edge after the last read bit releases the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select, asynchronous |
| sk_i | input | 1 | Shift clock, asynchronous |
| di_i | input | 1 | Serial data in, asynchronous |
| org16_i | input | 1 | Width strap: 1 selects 16-bit words, 0 selects bytes |
| do_o | output | 1 | Serial data out (dummy bit, read data or status) |
| do_oe_o | output | 1 | Output enable for `do_o` |

## Verification
The bench builds the block with its default sizes: a 6-bit word address, 16-bit data and an 80-clock programming cycle. With those values, every one of the 64 words can be written with a distinct arithmetic pattern and read back as words. All 128 byte addresses can also be read back in byte mode, which checks the half-word mapping completely. The short cycle lets the bench see busy and ready in a single status window. It also lets the bench raise select after the cycle has ended and confirm that no status appears, and check that the bulk fills reach every word within one cycle.

// File: rtl/twe_pkg.sv
package twe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_OPC, ST_ADDR, ST_DATA, ST_RD, ST_STAT, ST_HOLD
  } cmd_st_t;

  typedef enum logic [1:0] {
    PK_WORD, PK_ERASE, PK_FILL, PK_CLEAR
  } prog_kind_t;

  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  localparam logic [1:0] EXT_LOCK   = 2'b00;
  localparam logic [1:0] EXT_FILL   = 2'b01;
  localparam logic [1:0] EXT_CLEAR  = 2'b10;
  localparam logic [1:0] EXT_UNLOCK = 2'b11;
endpackage

// File: rtl/twe_sync.sv
module twe_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o
);
  logic [W-1:0] stage1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      level_o  <= '0;
    end else begin
      stage1_q <= async_i;
      level_o  <= stage1_q;
    end
  end
endmodule

// File: rtl/twe_array.sv
module twe_array #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic [LANES-1:0]          we_i,
  input  logic [ADDR_W-1:0]         waddr_i,
  input  logic [LANES*LANE_W-1:0]   wdata_i,
  input  logic [ADDR_W-1:0]         raddr_i,
  output logic [LANES*LANE_W-1:0]   rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we_i[l]) mem[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      rdata_o[l*LANE_W +: LANE_W] <= mem[raddr_i];
    end
  end
endmodule

// File: rtl/twe_prog.sv
module twe_prog
  import twe_pkg::*;
#(
  parameter int WADDR_W     = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 80
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               org16_i,
  input  logic               start_i,
  input  prog_kind_t         kind_i,
  input  logic [WADDR_W-1:0] waddr_i,
  input  logic               hi_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic               busy_o,
  output logic [1:0]         we_o,
  output logic [WADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0]  wr_data_o
);
  localparam int LANES    = 2;
  localparam int LANE_W   = DATA_W / LANES;
  localparam int WORDS    = 1 << WADDR_W;
  localparam int BUSY_CYC = (PROG_CYCLES > WORDS) ? PROG_CYCLES : WORDS;
  localparam int TMR_W    = $clog2(BUSY_CYC + 1);

  logic               busy_q;
  logic [TMR_W-1:0]   tmr_q;
  prog_kind_t         kind_q;
  logic [WADDR_W-1:0] addr_q;
  logic [WADDR_W-1:0] sweep_q;
  logic               hi_q;
  logic               org_q;
  logic [DATA_W-1:0]  data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      tmr_q   <= '0;
      kind_q  <= PK_WORD;
      addr_q  <= '0;
      sweep_q <= '0;
      hi_q    <= 1'b0;
      org_q   <= 1'b1;
      data_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q  <= 1'b1;
      tmr_q   <= TMR_W'(BUSY_CYC - 1);
      kind_q  <= kind_i;
      addr_q  <= waddr_i;
      sweep_q <= '0;
      hi_q    <= hi_i;
      org_q   <= org16_i;
      data_q  <= data_i;
    end else if (busy_q) begin
      sweep_q <= sweep_q + 1'b1;
      if (tmr_q == '0) busy_q <= 1'b0;
      else             tmr_q  <= tmr_q - 1'b1;
    end
  end

  logic              bulk;
  logic [DATA_W-1:0] src;
  assign bulk      = (kind_q == PK_FILL) || (kind_q == PK_CLEAR);
  assign src       = ((kind_q == PK_ERASE) || (kind_q == PK_CLEAR)) ? '1 : data_q;
  assign wr_addr_o = bulk ? sweep_q : addr_q;
  assign busy_o    = busy_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign wr_data_o[l*LANE_W +: LANE_W] = org_q ? src[l*LANE_W +: LANE_W] : src[LANE_W-1:0];
    assign we_o[l] = busy_q && (org_q || bulk || (hi_q == (l != 0)));
  end

  assert_busy_blocks_start_R10: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !busy_q);
  assert_start_begins_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    start_i |=> busy_q);
endmodule

// File: rtl/twe_cmd.sv
module twe_cmd
  import twe_pkg::*;
#(
  parameter int WADDR_W = 6,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               org16_i,
  input  logic               cs_lvl_i,
  input  logic               sk_lvl_i,
  input  logic               di_lvl_i,
  input  logic               busy_i,
  input  logic [DATA_W-1:0]  rd_word_i,
  output logic [WADDR_W-1:0] word_addr_o,
  output logic               hi_o,
  output logic               prog_start_o,
  output prog_kind_t         prog_kind_o,
  output logic [DATA_W-1:0]  prog_data_o,
  output logic               do_o,
  output logic               do_oe_o
);
  localparam int BYTE_W = DATA_W / 2;
  localparam int AW_MAX = WADDR_W + 1;
  localparam int CMAX   = (DATA_W > AW_MAX) ? DATA_W : AW_MAX;
  localparam int CNT_W  = $clog2(CMAX + 1);
  localparam int IDX_W  = $clog2(DATA_W);

  cmd_st_t            st_q;
  logic               cs_d, sk_d;
  logic [1:0]         opc_q;
  logic [AW_MAX-1:0]  addr_q;
  logic [DATA_W-1:0]  data_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               wen_q;
  logic               start_q;
  prog_kind_t         kind_q;
  logic               do_q, oe_q;

  logic               cs_rise, sk_rise;
  logic [AW_MAX-1:0]  addr_next;
  logic [DATA_W-1:0]  data_next;
  logic [1:0]         ext_mode;
  logic [CNT_W-1:0]   aw_last, dw_last, dw_len;
  logic [IDX_W-1:0]   word_idx, byte_idx;
  logic               rd_bit;

  assign cs_rise   = cs_lvl_i && !cs_d;
  assign sk_rise   = sk_lvl_i && !sk_d;
  assign addr_next = {addr_q[AW_MAX-2:0], di_lvl_i};
  assign data_next = {data_q[DATA_W-2:0], di_lvl_i};
  assign ext_mode  = org16_i ? addr_next[WADDR_W-1 -: 2] : addr_next[AW_MAX-1 -: 2];
  assign aw_last   = org16_i ? CNT_W'(WADDR_W - 1) : CNT_W'(AW_MAX - 1);
  assign dw_len    = org16_i ? CNT_W'(DATA_W) : CNT_W'(BYTE_W);
  assign dw_last   = dw_len - 1'b1;

  assign word_addr_o = org16_i ? addr_q[WADDR_W-1:0] : addr_q[AW_MAX-1:1];
  assign hi_o        = !org16_i && addr_q[0];

  assign word_idx = IDX_W'(DATA_W - 1) - IDX_W'(cnt_q);
  assign byte_idx = IDX_W'(BYTE_W - 1) - IDX_W'(cnt_q);
  assign rd_bit   = (org16_i || hi_o) ? rd_word_i[word_idx] : rd_word_i[byte_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cs_d    <= 1'b0;
      sk_d    <= 1'b0;
      opc_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
      wen_q   <= 1'b0;
      start_q <= 1'b0;
      kind_q  <= PK_WORD;
      do_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      cs_d    <= cs_lvl_i;
      sk_d    <= sk_lvl_i;
      start_q <= 1'b0;
      if (!cs_lvl_i) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
        do_q <= 1'b0;
      end else if (cs_rise) begin
        oe_q <= 1'b0;
        st_q <= busy_i ? ST_STAT : ST_START;
      end else begin
        unique case (st_q)
          ST_STAT: begin
            oe_q <= 1'b1;
            do_q <= !busy_i;
          end
          ST_START: if (sk_rise && di_lvl_i) begin
            st_q   <= ST_OPC;
            cnt_q  <= '0;
            addr_q <= '0;
          end
          ST_OPC: if (sk_rise) begin
            opc_q <= {opc_q[0], di_lvl_i};
            if (cnt_q == CNT_W'(1)) begin
              st_q  <= ST_ADDR;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_ADDR: if (sk_rise) begin
            addr_q <= addr_next;
            if (cnt_q != aw_last) begin
              cnt_q <= cnt_q + 1'b1;
            end else begin
              cnt_q <= '0;
              st_q  <= ST_HOLD;
              unique case (opc_q)
                OPC_READ: begin
                  st_q <= ST_RD;
                  oe_q <= 1'b1;
                  do_q <= 1'b0;
                end
                OPC_WRITE: begin
                  kind_q <= PK_WORD;
                  if (wen_q) st_q <= ST_DATA;
                end
                OPC_ERASE: begin
                  kind_q  <= PK_ERASE;
                  start_q <= wen_q;
                end
                default: begin
                  unique case (ext_mode)
                    EXT_UNLOCK: wen_q <= 1'b1;
                    EXT_LOCK:   wen_q <= 1'b0;
                    EXT_CLEAR: begin
                      kind_q  <= PK_CLEAR;
                      start_q <= wen_q;
                    end
                    default: begin
                      kind_q <= PK_FILL;
                      if (wen_q) st_q <= ST_DATA;
                    end
                  endcase
                end
              endcase
            end
          end
          ST_DATA: if (sk_rise) begin
            data_q <= data_next;
            if (cnt_q == dw_last) begin
              start_q <= 1'b1;
              st_q    <= ST_HOLD;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_RD: if (sk_rise) begin
            if (cnt_q == dw_len) begin
              oe_q <= 1'b0;
              st_q <= ST_HOLD;
            end else begin
              do_q  <= rd_bit;
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign prog_start_o = start_q;
  assign prog_kind_o  = kind_q;
  assign prog_data_o  = data_q;
  assign do_o         = do_q;
  assign do_oe_o      = oe_q;

  assert_deselect_float_R11: assert property (@(posedge clk) disable iff (rst)
    !cs_lvl_i |=> !oe_q);
  assert_dummy_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RD && $past(st_q) == ST_ADDR) |-> (oe_q && !do_q));
  assert_status_tracks_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(st_q) == ST_STAT && $past(cs_lvl_i)) |-> (oe_q && (do_q == !$past(busy_i))));
  assert_locked_no_start_R4: assert property (@(posedge clk) disable iff (rst)
    start_q |-> $past(wen_q));
endmodule

// File: rtl/tw_eeprom_target.sv
module tw_eeprom_target
  import twe_pkg::*;
#(
  parameter int WADDR_W     = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  input  logic org16_i,
  output logic do_o,
  output logic do_oe_o
);
  localparam int LANES  = 2;
  localparam int LANE_W = DATA_W / LANES;

  logic [2:0]         pin_lvl;
  logic               busy;
  logic [DATA_W-1:0]  rd_word;
  logic [WADDR_W-1:0] word_addr;
  logic               hi_sel;
  logic               prog_start;
  prog_kind_t         prog_kind;
  logic [DATA_W-1:0]  prog_data;
  logic [LANES-1:0]   we;
  logic [WADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0]  wr_data;

  twe_sync #(.W(3)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({cs_i, sk_i, di_i}),
    .level_o (pin_lvl)
  );

  twe_cmd #(.WADDR_W(WADDR_W), .DATA_W(DATA_W)) u_cmd (
    .clk          (clk),
    .rst          (rst),
    .org16_i      (org16_i),
    .cs_lvl_i     (pin_lvl[2]),
    .sk_lvl_i     (pin_lvl[1]),
    .di_lvl_i     (pin_lvl[0]),
    .busy_i       (busy),
    .rd_word_i    (rd_word),
    .word_addr_o  (word_addr),
    .hi_o         (hi_sel),
    .prog_start_o (prog_start),
    .prog_kind_o  (prog_kind),
    .prog_data_o  (prog_data),
    .do_o         (do_o),
    .do_oe_o      (do_oe_o)
  );

  twe_prog #(.WADDR_W(WADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk       (clk),
    .rst       (rst),
    .org16_i   (org16_i),
    .start_i   (prog_start),
    .kind_i    (prog_kind),
    .waddr_i   (word_addr),
    .hi_i      (hi_sel),
    .data_i    (prog_data),
    .busy_o    (busy),
    .we_o      (we),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  twe_array #(.ADDR_W(WADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk     (clk),
    .we_i    (we),
    .waddr_i (wr_addr),
    .wdata_i (wr_data),
    .raddr_i (word_addr),
    .rdata_o (rd_word)
  );
endmodule

// File: tb/tw_eeprom_target_bench.sv
module tw_eeprom_target_bench;
  localparam int WADDR_W     = 6;
  localparam int DATA_W      = 16;
  localparam int PROG_CYCLES = 80;
  localparam int WORDS       = 1 << WADDR_W;
  localparam int WAIT_PROG   = PROG_CYCLES + 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0, org16 = 1'b1;
  logic do_w, oe_w;
  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;
  logic [15:0] model [WORDS];

  always #4 clk = ~clk;

  tw_eeprom_target #(.WADDR_W(WADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES))
    u_tw_eeprom_target (
      .clk(clk), .rst(rst), .cs_i(cs), .sk_i(sk), .di_i(di), .org16_i(org16),
      .do_o(do_w), .do_oe_o(oe_w));

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 16'h0497) ^ 16'hC35A);
  endfunction

  function automatic logic [7:0] byte_at(input int b);
    return b[0] ? model[b >> 1][15:8] : model[b >> 1][7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_up();
    cs = 1'b1; wclk(6);
  endtask

  task automatic cs_down();
    cs = 1'b0; wclk(6);
  endtask

  task automatic bit_out(input logic b);
    di = b; wclk(4); sk = 1'b1; wclk(4); sk = 1'b0;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
  endtask

  // read one location; npre leading zeros, tail adds a release pulse
  task automatic rd(input bit o16, input int addr, input string req, input int exp,
                    input int npre, input bit tail);
    int aw, dw;
    logic [15:0] got;
    aw = o16 ? 6 : 7;
    dw = o16 ? 16 : 8;
    org16 = o16;
    cs_up();
    send(0, npre);
    send(3'b110, 3);
    send(addr, aw);
    chk(oe_w === 1'b1 && do_w === 1'b0, "R3 dummy bit", {oe_w, do_w}, 2);
    got = '0;
    for (int i = 0; i < dw; i++) begin
      bit_out(1'b0);
      got = {got[14:0], do_w};
    end
    chk(got === 16'(exp), req, got, exp);
    if (tail) begin
      bit_out(1'b0);
      chk(oe_w === 1'b0, "R11 release after last bit", oe_w, 0);
    end
    cs_down();
  endtask

  task automatic prog(input bit o16, input logic [1:0] op, input int addr,
                      input bit has_data, input int data);
    int aw, dw;
    aw = o16 ? 6 : 7;
    dw = o16 ? 16 : 8;
    org16 = o16;
    cs_up();
    send({1'b1, op}, 3);
    send(addr, aw);
    if (has_data) send(data, dw);
    cs_down();
  endtask

  task automatic ext(input bit o16, input logic [1:0] mode, input bit has_data, input int data);
    prog(o16, 2'b00, o16 ? (int'(mode) << 4) : (int'(mode) << 5), has_data, data);
  endtask

  task automatic no_status(input string req);
    cs_up();
    chk(oe_w === 1'b0, req, oe_w, 0);
    cs_down();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wclk(10);
    rst = 1'b0;
    wclk(4);
    chk(oe_w === 1'b0, "R11 reset output released", oe_w, 0);

    // R4: locked after reset, erase-all starts nothing
    ext(1'b1, 2'b10, 1'b0, 0);
    no_status("R4 locked erase-all no cycle");

    // R7 erase-all, R8 status busy then ready
    ext(1'b1, 2'b11, 1'b0, 0);
    ext(1'b1, 2'b10, 1'b0, 0);
    cs_up();
    chk(oe_w === 1'b1 && do_w === 1'b0, "R8 status busy", {oe_w, do_w}, 2);
    wclk(WAIT_PROG);
    chk(oe_w === 1'b1 && do_w === 1'b1, "R8 status ready", {oe_w, do_w}, 3);
    cs_down();
    chk(oe_w === 1'b0, "R11 select low releases", oe_w, 0);
    for (int a = 0; a < WORDS; a++) model[a] = 16'hFFFF;
    for (int a = 0; a < WORDS; a++) rd(1'b1, a, "R7 erase-all word", model[a], 0, 1'b0);

    // R5 write every word with a distinct pattern
    for (int a = 0; a < WORDS; a++) begin
      prog(1'b1, 2'b01, a, 1'b1, pat(a));
      wclk(WAIT_PROG);
      model[a] = pat(a);
    end
    for (int a = 0; a < WORDS; a++) rd(1'b1, a, "R5 word write", model[a], 0, 1'b0);

    // R2 byte view of every location
    for (int b = 0; b < 2 * WORDS; b++) rd(1'b0, b, "R2 byte map", byte_at(b), 0, 1'b0);

    // R4 relock: programming ignored, read still works (R3)
    ext(1'b1, 2'b00, 1'b0, 0);
    prog(1'b1, 2'b01, 9, 1'b1, 16'h0000);
    no_status("R4 locked write no cycle");
    prog(1'b1, 2'b11, 10, 1'b0, 0);
    ext(1'b1, 2'b10, 1'b0, 0);
    ext(1'b0, 2'b01, 1'b1, 8'h00);
    wclk(WAIT_PROG);
    rd(1'b1, 9, "R4 locked write ignored", model[9], 0, 1'b0);
    rd(1'b1, 10, "R4 locked erase ignored", model[10], 0, 1'b0);
    rd(1'b1, 11, "R3 read while locked", model[11], 0, 1'b0);

    // R2/R5 byte writes land in the right half
    ext(1'b1, 2'b11, 1'b0, 0);
    prog(1'b0, 2'b01, 8'h21, 1'b1, 8'h5A);
    wclk(WAIT_PROG);
    model[16][15:8] = 8'h5A;
    rd(1'b1, 16, "R2 byte write upper half", model[16], 0, 1'b0);
    prog(1'b0, 2'b01, 8'h40, 1'b1, 8'h96);
    wclk(WAIT_PROG);
    model[32][7:0] = 8'h96;
    rd(1'b1, 32, "R2 byte write lower half", model[32], 0, 1'b0);

    // R6 erase byte and word
    prog(1'b0, 2'b11, 5, 1'b0, 0);
    wclk(WAIT_PROG);
    model[2][15:8] = 8'hFF;
    rd(1'b1, 2, "R6 byte erase keeps other half", model[2], 0, 1'b0);
    prog(1'b1, 2'b11, 4, 1'b0, 0);
    wclk(WAIT_PROG);
    model[4] = 16'hFFFF;
    rd(1'b1, 4, "R6 word erase", model[4], 0, 1'b0);

    // R1 leading zeros skipped
    rd(1'b1, 12, "R1 leading zeros", model[12], 2, 1'b0);

    // R1 aborted command discarded
    org16 = 1'b1;
    cs_up();
    send(3'b101, 3);
    send(20, 6);
    send(5'h15, 5);
    cs_down();
    no_status("R1 abort starts no cycle");
    rd(1'b1, 20, "R1 abort leaves word", model[20], 0, 1'b0);

    // R9 no status after cycle ended
    prog(1'b1, 2'b01, 30, 1'b1, 16'h1234);
    wclk(WAIT_PROG);
    model[30] = 16'h1234;
    no_status("R9 late select no status");
    rd(1'b1, 30, "R5 write after late select", model[30], 0, 1'b0);

    // R10 command during busy ignored, R8 ready shown in same window
    prog(1'b1, 2'b01, 40, 1'b1, 16'hBEEF);
    model[40] = 16'hBEEF;
    cs_up();
    chk(oe_w === 1'b1 && do_w === 1'b0, "R10 busy shows status", {oe_w, do_w}, 2);
    send(3'b101, 3);
    send(41, 6);
    send(16'h0000, 16);
    chk(oe_w === 1'b1 && do_w === 1'b1, "R8 ready after command ignored", {oe_w, do_w}, 3);
    cs_down();
    rd(1'b1, 41, "R10 busy write ignored", model[41], 0, 1'b0);
    rd(1'b1, 40, "R11 read then release", model[40], 0, 1'b1);

    // R7 write-all in byte mode
    ext(1'b0, 2'b01, 1'b1, 8'h3C);
    wclk(WAIT_PROG);
    for (int a = 0; a < WORDS; a++) model[a] = 16'h3C3C;
    for (int a = 0; a < WORDS; a++) rd(1'b1, a, "R7 byte write-all", model[a], 0, 1'b0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule